// File: doc/BRIEF.md
# Programmable Interval Timer with Interrupt Request

This block measures elapsed time on a 12-bit counter. The counter advances once for every pulse on a tick input, which normally comes from a quarter-millisecond divider outside the block. Software programs a 12-bit interval and a mode through a write port. When the elapsed time reaches the interval, the block raises an interrupt request. It can also raise a request for two error conditions: the counter has overflowed, or the elapsed time has already passed the interval. Each request reports its cause in a status byte, together with a wrapping 4-bit count of all requests raised so far.

A write can either keep the present zero reference or clear the counter to start a new one. It selects either a single interrupt or an interrupt on every interval. A read word returns the elapsed time, the overflow flag and the armed flag. The request output stays high until the host pulses an acknowledge for one cycle. Only one request is outstanding at a time.

The control state machine has three states. Idle means not armed. Armed means waiting for the interval. Request means a request is raised and not yet acknowledged. Its transitions are:

- program: from any state to Armed, on a write.
- fire: from Armed to Request, when a cause is detected.
- re-arm: from Request to Armed, on acknowledge of a time-elapsed request in repeat mode.
- retire: from Request to Idle, on acknowledge of any other request.

Top module: `tick_interval_timer`

## Requirements
- R1: A write (`wr_en_i` high for one cycle) loads the interval from data bits [TIME_W-1:0]. It copies data bit [DW-2] into the repeat mode and sets the armed flag. The armed flag reads back as bit [DW-2] of `rd_data_o`.
- R2: Data bit [DW-1] of a write selects the zero reference. A 1 clears the elapsed time and the overflow flag. A 0 keeps the current elapsed time and the current overflow flag.
- R3: Each cycle with `tick_i` high adds one to the elapsed time, so the first tick after a clear reads 1. `rd_data_o` reads as {overflow flag, armed flag, 2'b00, elapsed time}.
- R4: Armed, with the overflow flag 0 and the elapsed time equal to the interval, the block raises `irq_req_o` on the next clock edge. The cause code is 2'b01, and the elapsed time is cleared on that same edge.
- R5: In single mode, a time-elapsed request leaves the armed flag at 0. No further request is raised until the next write.
- R6: In repeat mode, the armed flag stays 1 through a time-elapsed request. After acknowledge, the next request follows after another full interval.
- R7: A tick at the maximum elapsed time wraps the count to 0 and sets the overflow flag. Armed with the overflow flag at 1, the block raises a request with cause code 2'b10. This request does not clear the elapsed time.
- R8: Armed, with the overflow flag 0 and the elapsed time greater than the interval, the block raises a request with cause code 2'b11. After either error request, acknowledge clears the armed flag, and no further request is raised until the next write.
- R9: `status_o` is {cause code[1:0], 2'b00, request count[3:0]}. The count rises by one with every raised request and wraps from 15 to 0.
- R10: `irq_req_o` stays high, and `status_o` stays unchanged, until a one-cycle `irq_ack_i` or a write. No second request is raised while one is pending.
- R11: A write cancels a pending request on the same edge. No cause is evaluated in the write cycle; evaluation resumes on the next cycle using only the state that write produced.
- R12: After reset, `rd_data_o` shows the overflow flag 1, the armed flag 0 and elapsed time 0. `irq_req_o` is 0, and `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| tick_i | input | 1 | One-cycle time-unit pulse |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DW (TIME_W+4) | Write word: zero-reference select, repeat select, two spare bits, interval |
| rd_data_o | output | DW (TIME_W+4) | Overflow flag, armed flag, two zero bits, elapsed time |
| irq_req_o | output | 1 | Interrupt request, held until acknowledge |
| irq_ack_i | input | 1 | One-cycle acknowledge |
| status_o | output | 8 | Cause code, two zero bits, request count |

## Verification
The bench builds the timer with TIME_W set to 4. This makes the elapsed-time counter wrap after 16 ticks. As a result, every interval value from 0 to 15 can be swept, and the overflow carry can be reached within a few dozen cycles. More than sixteen requests are raised, so the 4-bit request count wraps through 0. The small width also brings late-interval errors and repeat-mode sequences into reach cheaply. Expected tick counts, read words and status bytes are derived arithmetically from the interval and mode written.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Cause codes: the value is the two flag bits of the status byte
    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'b00,
        CAUSE_ELAPSED = 2'b01,
        CAUSE_OVF     = 2'b10,
        CAUSE_LATE    = 2'b11
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ARMED = 2'b01,
        ST_REQ   = 2'b10
    } tmr_state_e;

endpackage

// File: rtl/tmr_elapsed.sv
module tmr_elapsed #(
    parameter int TIME_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              zero_i,
    output logic [TIME_W-1:0] time_o,
    output logic              of_o
);
    localparam logic [TIME_W:0]   STEP_X = (TIME_W+1)'(1);
    localparam logic [TIME_W-1:0] STEP   = TIME_W'(1);

    logic [TIME_W-1:0] time_q;
    logic              of_q;
    logic [TIME_W:0]   sum;

    assign sum = {1'b0, time_q} + STEP_X;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_q <= '0;
            of_q   <= 1'b1;
        end else if (zero_i) begin
            time_q <= '0;
            of_q   <= 1'b0;
        end else if (tick_i) begin
            time_q <= sum[TIME_W-1:0];
            if (sum[TIME_W]) of_q <= 1'b1;
        end
    end

    assign time_o = time_q;
    assign of_o   = of_q;

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !zero_i) |=> (time_q == $past(time_q) + STEP));

    // R7
    carry_of_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !zero_i && (&time_q)) |=> (of_q && time_q == '0));

    // R2
    new_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_i |=> (time_q == '0 && !of_q));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !zero_i) |=> ($stable(time_q) && $stable(of_q)));

endmodule

// File: rtl/tmr_cause.sv
module tmr_cause
    import tmr_pkg::*;
#(
    parameter int TIME_W = 12
) (
    input  logic [TIME_W-1:0] time_i,
    input  logic [TIME_W-1:0] intv_i,
    input  logic              of_i,
    output cause_e            cause_o
);
    always_comb begin
        if (of_i)                 cause_o = CAUSE_OVF;
        else if (time_i > intv_i) cause_o = CAUSE_LATE;
        else if (time_i == intv_i) cause_o = CAUSE_ELAPSED;
        else                      cause_o = CAUSE_NONE;
    end
endmodule

// File: rtl/tmr_evcount.sv
module tmr_evcount #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (bump_i) cnt_q <= cnt_q + STEP;
    end

    assign cnt_o = cnt_q;

    // R9
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bump_i && (&cnt_q)) |=> (cnt_q == '0));

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bump_i |=> $stable(cnt_q));

endmodule

// File: rtl/tick_interval_timer.sv
module tick_interval_timer
    import tmr_pkg::*;
#(
    parameter int TIME_W = 12,
    parameter int CNT_W  = 4,
    localparam int DW     = TIME_W + 4,
    localparam int STAT_W = CNT_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [DW-1:0]     wr_data_i,
    output logic [DW-1:0]     rd_data_o,
    output logic              irq_req_o,
    input  logic              irq_ack_i,
    output logic [STAT_W-1:0] status_o
);
    localparam int M_BIT = DW - 1;
    localparam int N_BIT = DW - 2;

    tmr_state_e        st_q, st_nxt;
    cause_e            cause_now, cause_q;
    logic [TIME_W-1:0] intv_q;
    logic              rep_q;
    logic [TIME_W-1:0] time_w;
    logic              of_w;
    logic [CNT_W-1:0]  cnt_w;
    logic              fire, zero_ref, armed_flag;
    logic              spare_unused;

    assign spare_unused = ^wr_data_i[DW-3 -: 2];

    tmr_elapsed #(.TIME_W(TIME_W)) u_elapsed (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .zero_i(zero_ref),
        .time_o(time_w), .of_o(of_w)
    );

    tmr_cause #(.TIME_W(TIME_W)) u_cause (
        .time_i(time_w), .intv_i(intv_q), .of_i(of_w), .cause_o(cause_now)
    );

    tmr_evcount #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .bump_i(fire), .cnt_o(cnt_w)
    );

    // evaluation only while armed and not in a write cycle
    assign fire     = (st_q == ST_ARMED) && !wr_en_i && (cause_now != CAUSE_NONE);
    assign zero_ref = (wr_en_i && wr_data_i[M_BIT]) ||
                      (fire && cause_now == CAUSE_ELAPSED);

    // next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (wr_en_i) st_nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (wr_en_i)   st_nxt = ST_ARMED;
                else if (fire) st_nxt = ST_REQ;
            end
            ST_REQ: begin
                if (wr_en_i)
                    st_nxt = ST_ARMED;
                else if (irq_ack_i)
                    st_nxt = (cause_q == CAUSE_ELAPSED && rep_q) ? ST_ARMED : ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // programmed interval, mode and latched cause
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            intv_q  <= '0;
            rep_q   <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            if (wr_en_i) begin
                intv_q <= wr_data_i[TIME_W-1:0];
                rep_q  <= wr_data_i[N_BIT];
            end
            if (fire) cause_q <= cause_now;
        end
    end

    // outputs
    always_comb begin
        irq_req_o  = (st_q == ST_REQ);
        armed_flag = (st_q == ST_ARMED) ||
                     ((st_q == ST_REQ) && (cause_q != CAUSE_ELAPSED || rep_q));
        rd_data_o  = {of_w, armed_flag, 2'b00, time_w};
        status_o   = {cause_q, 2'b00, cnt_w};
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !irq_ack_i && !wr_en_i) |=> irq_req_o);

    // R10
    status_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && !irq_ack_i && !wr_en_i) |=> $stable(status_o));

    // R11
    wr_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (!irq_req_o && rd_data_o[N_BIT]));

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o) |-> (status_o[CNT_W-1:0] == $past(status_o[CNT_W-1:0]) + CNT_W'(1)));

    // R4
    code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (status_o[STAT_W-1 -: 2] != 2'b00));

    // R8
    err_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && irq_ack_i && !wr_en_i && status_o[STAT_W-1]) |=>
            (!rd_data_o[N_BIT] && !irq_req_o));

endmodule

// File: tb/tick_interval_timer_test.sv
`timescale 1ns/1ps
module tick_interval_timer_test;
    localparam int TW = 4;
    localparam int DW = TW + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          irq_ack = 1'b0;
    logic [DW-1:0] rd_data;
    logic          irq_req;
    logic [7:0]    status;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic [3:0] ecnt = 4'd0;

    always #2.5 clk = ~clk;

    tick_interval_timer #(.TIME_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .rd_data_o(rd_data), .irq_req_o(irq_req),
        .irq_ack_i(irq_ack), .status_o(status)
    );

    task automatic check(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic cyc(input logic t);
        tick = t;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic wr(input logic m, input logic n, input int iv);
        wr_en   = 1'b1;
        wr_data = {m, n, 2'b00, iv[TW-1:0]};
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic wait_req(output int n);
        n = 0;
        while (!irq_req && n < 40) begin
            cyc(1'b1);
            cyc(1'b0);
            n++;
        end
    endtask

    function automatic int rdw(input int of, input int d, input int t);
        return (of << (DW-1)) | (d << (DW-2)) | t;
    endfunction

    function automatic int stw(input int code, input logic [3:0] c);
        return (code << 6) | c;
    endfunction

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check("R12 read word", rd_data, rdw(1, 0, 0));
        check("R12 request", irq_req, 0);
        check("R12 status", status, 0);

        // R7 armed while overflow flag set from reset
        wr(1'b0, 1'b0, 5);
        check("R11 no eval in write cycle", irq_req, 0);
        check("R1 armed after write", rd_data, rdw(1, 1, 0));
        cyc(1'b0);
        ecnt++;
        check("R7 overflow request", irq_req, 1);
        check("R7 overflow code", status, stw(2, ecnt));
        ack();
        check("R8 disarm after error ack", rd_data, rdw(1, 0, 0));

        // R4 R5 single-shot sweep of every interval
        for (int i = 0; i < 16; i++) begin
            wr(1'b1, 1'b0, i);
            check("R2 new zero reference", rd_data, rdw(0, 1, 0));
            cyc(1'b0);
            wait_req(n);
            ecnt++;
            check("R4 ticks to request", n, i);
            check("R9 elapsed status", status, stw(1, ecnt));
            check("R5 disarmed, time cleared", rd_data, rdw(0, 0, 0));
            ack();
            check("R5 request dropped", irq_req, 0);
            cyc(1'b1); cyc(1'b0); cyc(1'b1); cyc(1'b0);
            check("R5 no further request", irq_req, 0);
            check("R3 counting after clear", rd_data, rdw(0, 0, 2));
        end

        // R6 repeat mode
        wr(1'b1, 1'b1, 3);
        cyc(1'b0);
        for (int k = 0; k < 3; k++) begin
            wait_req(n);
            ecnt++;
            check("R6 repeat interval", n, 3);
            check("R6 repeat status", status, stw(1, ecnt));
            check("R6 stays armed", rd_data, rdw(0, 1, 0));
            ack();
            check("R6 re-armed after ack", rd_data, rdw(0, 1, 0));
        end

        // R10 pending request held while time runs
        wait_req(n);
        ecnt++;
        check("R10 fired", irq_req, 1);
        for (int k = 0; k < 6; k++) begin
            cyc(1'b1);
            check("R10 request held", irq_req, 1);
            check("R10 status stable", status, stw(1, ecnt));
        end
        check("R3 read while pending", rd_data, rdw(0, 1, 6));
        ack();
        cyc(1'b0);
        ecnt++;
        check("R8 late after re-arm", status, stw(3, ecnt));
        check("R8 late request", irq_req, 1);
        ack();
        check("R8 disarmed", rd_data, rdw(0, 0, 6));
        cyc(1'b1); cyc(1'b0); cyc(1'b1); cyc(1'b0);
        check("R8 no further request", irq_req, 0);
        check("R3 read word", rd_data, rdw(0, 0, 8));

        // R2 keep reference with bit clear
        wr(1'b1, 1'b0, 10);
        for (int k = 0; k < 4; k++) cyc(1'b1);
        check("R3 four ticks", rd_data, rdw(0, 1, 4));
        wr(1'b0, 1'b0, 9);
        check("R2 time kept", rd_data, rdw(0, 1, 4));
        for (int k = 0; k < 5; k++) cyc(1'b1);
        check("R2 no early request", irq_req, 0);
        cyc(1'b0);
        ecnt++;
        check("R2 old reference hit", irq_req, 1);
        check("R2 hit status", status, stw(1, ecnt));
        ack();

        // R8 write with interval already passed
        for (int k = 0; k < 4; k++) cyc(1'b1);
        wr(1'b0, 1'b0, 2);
        check("R11 held in write cycle", irq_req, 0);
        cyc(1'b0);
        ecnt++;
        check("R8 late code", status, stw(3, ecnt));
        check("R8 armed while pending", rd_data, rdw(0, 1, 4));
        ack();
        check("R8 ack clears armed", rd_data, rdw(0, 0, 4));

        // R7 carry out of counter
        for (int k = 0; k < 11; k++) cyc(1'b1);
        check("R3 at maximum", rd_data, rdw(0, 0, 15));
        cyc(1'b1);
        check("R7 carry sets flag", rd_data, rdw(1, 0, 0));
        for (int k = 0; k < 3; k++) cyc(1'b1);
        wr(1'b0, 1'b0, 7);
        check("R2 flag kept", rd_data, rdw(1, 1, 3));
        cyc(1'b0);
        ecnt++;
        check("R7 overflow status", status, stw(2, ecnt));
        check("R7 time not cleared", rd_data, rdw(1, 1, 3));
        ack();
        check("R7 after ack", rd_data, rdw(1, 0, 3));
        wr(1'b1, 1'b0, 2);
        check("R2 flag cleared", rd_data, rdw(0, 1, 0));

        // R11 write cancels pending request
        wr(1'b1, 1'b0, 0);
        cyc(1'b0);
        ecnt++;
        check("R11 pending", irq_req, 1);
        wr(1'b1, 1'b0, 5);
        check("R11 cancelled", irq_req, 0);
        check("R11 count unchanged", status, stw(1, ecnt));
        wait_req(n);
        ecnt++;
        check("R11 state from write only", n, 5);
        check("R9 count", status, stw(1, ecnt));
        ack();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog actual=expired expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule